// File: doc/BRIEF.md
# Dual-Clock Compare-Match Timer Channel

This block is one 32-bit timer channel with a compare register. Software programs it through a small register window clocked by the bus clock. The count itself is paced by a slow reference clock of roughly 32 kHz. That reference is sampled into the bus domain, where each rising edge is detected and fed to a prescaler. The prescaler produces the count ticks at a selectable ratio of the reference.

The counter has two modes:
- **Free-running:** it counts through its full range and raises an overflow flag when it wraps.
- **Periodic:** it returns to zero on the tick at which it equals the compare value.

A match flag records each compare hit in both modes. The match and overflow events, together with start and stop status flags, can drive one level-sensitive interrupt request.

Software updates of the counter are paced by the reference clock. A written value is held in a shadow and lands only on the second reference edge after the write. A busy bit shows that a load is pending, and a further counter write during that window is dropped.

Top module: `cmt_channel`

## Requirements
- R1: After reset, the control word (offset 0x10) reads 0, the counter (0x14) reads 0, the compare register (0x18) reads 0xFFFFFFFF, the start register (0x00) reads 0 and `irq` is low.
- R2: With clock select 7 in control bits [2:0] and the channel running (start register bit 0 = 1), the counter advances by one on every rising reference edge.
- R3: Clock select 4 advances the counter once per 8 reference edges, and select 5 once per 32. Select 6 divides by 128. Selects 0 to 3 halt counting. The prescaler restarts from zero whenever the channel is stopped.
- R4: A counter write reaches the counter on the second reference edge after the write, and reads return the old value until then. Control bit 13 reads 1 while the load is pending. A second counter write during that window is ignored.
- R5: In free-running mode (control bit 8 = 0), a tick taken while the counter equals the compare value sets the match flag (bit 15), and the counter still increments.
- R6: In periodic mode (control bit 8 = 1), such a tick sets the match flag and returns the counter to 0, giving a period of compare+1 ticks.
- R7: A tick at 0xFFFFFFFF wraps the counter to 0 and sets the overflow flag (bit 14).
- R8: Writing the control word with bit 15 or bit 14 at 0 clears that flag. Writing 1 leaves it unchanged. Software cannot set either flag.
- R9: `irq` is high while control bits [5:4] equal 2, bit 7 is 1 and the match or overflow flag is set. Any other routing value, or bit 7 at 0, masks these events.
- R10: Writing start bit 0 from 0 to 1 sets status bit 12, and from 1 to 0 sets bit 11. Both clear by writing 0. When bit 10 is 1, either of them raises `irq`.
- R11: While the channel is stopped, reference edges do not change the counter except to complete a pending load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk | input | 1 | Slow reference clock, asynchronous to `clk` |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt request |

## Verification
The counting path is driven with single reference pulses under each clock select. Undivided counting shows that every edge is seen exactly once. The divided selects show that the prescaler boundary falls on the 8th and 32nd edge and not one edge early, and a halting select shows that counting stops. The compare path is driven under each mode setting:
- A compare value of 3 in free-running mode is checked against periodic mode, which tells a counter that clears on match from one that keeps counting.
- A preload just below the wrap point isolates the overflow flag.

The interrupt gating is walked through each combination of routing field, enable bit and pending flag. A double counter write, with reads between the reference pulses, separates load timing from load acceptance.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_START = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CTL   = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_CNT   = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_CMP   = 8'h18;

  localparam int B_MATCH  = 15;
  localparam int B_OVF    = 14;
  localparam int B_BUSY   = 13;
  localparam int B_STARTF = 12;
  localparam int B_STOPF  = 11;
  localparam int B_SSIE   = 10;
  localparam int B_MODE9  = 9;
  localparam int B_PERIOD = 8;
  localparam int B_IE     = 7;

  localparam logic [1:0] ROUTE_IRQ = 2'd2;

  typedef struct packed {
    logic       ssie;
    logic       mode9;
    logic       periodic;
    logic       ie;
    logic [1:0] route;
    logic [2:0] cks;
  } ctl_cfg_t;
endpackage

// File: rtl/cmt_ref_sync.sv
module cmt_ref_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_i,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= ref_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sync_q[STAGES-1];
  end

  assign edge_o = sync_q[STAGES-1] & ~last_q;

  // R2
  single_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> !edge_o);
endmodule

// File: rtl/cmt_prescaler.sv
module cmt_prescaler #(
  parameter int DIV_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_i,
  input  logic       slow_edge_i,
  input  logic [2:0] sel_i,
  output logic       tick_o
);
  logic [DIV_W-1:0] pcnt_q, pcnt_d;
  logic [DIV_W-1:0] limit;
  logic             enabled;

  always_comb begin
    case (sel_i)
      3'd4:    limit = DIV_W'(7);
      3'd5:    limit = DIV_W'(31);
      3'd6:    limit = DIV_W'(127);
      default: limit = '0;
    endcase
  end

  assign enabled = run_i & sel_i[2];

  always_comb begin
    pcnt_d = pcnt_q;
    tick_o = 1'b0;
    if (!enabled) begin
      pcnt_d = '0;
    end else if (slow_edge_i) begin
      if (pcnt_q >= limit) begin
        pcnt_d = '0;
        tick_o = 1'b1;
      end else begin
        pcnt_d = pcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  // R3
  halt_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> pcnt_q == '0);
endmodule

// File: rtl/cmt_count_core.sv
module cmt_count_core #(
  parameter int CNT_W    = 32,
  parameter int LOAD_LAT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_edge_i,
  input  logic             tick_i,
  input  logic             periodic_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pend_o,
  output logic             match_o,
  output logic             ovf_o
);
  localparam int LAT_W = $clog2(LOAD_LAT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d, wval_q, wval_d;
  logic             pend_q, pend_d;
  logic [LAT_W-1:0] lat_q, lat_d;
  logic             load_now;

  assign load_now = pend_q & slow_edge_i & (lat_q == LAT_W'(LOAD_LAT - 1));

  always_comb begin
    cnt_d   = cnt_q;
    wval_d  = wval_q;
    pend_d  = pend_q;
    lat_d   = lat_q;
    match_o = 1'b0;
    ovf_o   = 1'b0;
    if (load_now) begin
      cnt_d  = wval_q;
      pend_d = 1'b0;
      lat_d  = '0;
    end else begin
      if (pend_q && slow_edge_i) lat_d = lat_q + 1'b1;
      if (wr_i && !pend_q) begin
        pend_d = 1'b1;
        wval_d = wdata_i;
        lat_d  = '0;
      end
      if (tick_i) begin
        match_o = (cnt_q == cmp_i);
        if (periodic_i && match_o) begin
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
          ovf_o = (cnt_q == CNT_MAX);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wval_q <= '0;
      pend_q <= 1'b0;
      lat_q  <= '0;
    end else begin
      cnt_q  <= cnt_d;
      wval_q <= wval_d;
      pend_q <= pend_d;
      lat_q  <= lat_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign pend_o = pend_q;

  // R4
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !slow_edge_i) |=> pend_q);
  // R4
  pend_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(wr_i));
  // R11
  cnt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !slow_edge_i) |=> $stable(cnt_q));
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
  import cmt_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LOAD_LAT    = 2,
  parameter int DIV_W       = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_clk,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  ctl_cfg_t          cfg_q, cfg_d;
  logic              run_q, run_d;
  logic              mflag_q, mflag_d, oflag_q, oflag_d;
  logic              stf_q, stf_d, spf_q, spf_d;
  logic [DATA_W-1:0] cmp_q, cmp_d;
  logic              wr_start, wr_ctl, wr_cnt, wr_cmp;
  logic              slow_edge, tick, pend, match_ev, ovf_ev;
  logic [DATA_W-1:0] cnt;

  assign wr_start = bus_we && (bus_addr == OFS_START);
  assign wr_ctl   = bus_we && (bus_addr == OFS_CTL);
  assign wr_cnt   = bus_we && (bus_addr == OFS_CNT);
  assign wr_cmp   = bus_we && (bus_addr == OFS_CMP);

  cmt_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .ref_i(ref_clk), .edge_o(slow_edge));

  cmt_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .run_i(run_q), .slow_edge_i(slow_edge),
    .sel_i(cfg_q.cks), .tick_o(tick));

  cmt_count_core #(.CNT_W(DATA_W), .LOAD_LAT(LOAD_LAT)) u_core (
    .clk(clk), .rst_n(rst_n), .slow_edge_i(slow_edge), .tick_i(tick),
    .periodic_i(cfg_q.periodic), .cmp_i(cmp_q), .wr_i(wr_cnt),
    .wdata_i(bus_wdata), .cnt_o(cnt), .pend_o(pend),
    .match_o(match_ev), .ovf_o(ovf_ev));

  always_comb begin
    cfg_d   = cfg_q;
    run_d   = run_q;
    cmp_d   = cmp_q;
    mflag_d = mflag_q;
    oflag_d = oflag_q;
    stf_d   = stf_q;
    spf_d   = spf_q;
    if (wr_ctl) begin
      cfg_d.ssie     = bus_wdata[B_SSIE];
      cfg_d.mode9    = bus_wdata[B_MODE9];
      cfg_d.periodic = bus_wdata[B_PERIOD];
      cfg_d.ie       = bus_wdata[B_IE];
      cfg_d.route    = bus_wdata[5:4];
      cfg_d.cks      = bus_wdata[2:0];
      mflag_d = mflag_q & bus_wdata[B_MATCH];
      oflag_d = oflag_q & bus_wdata[B_OVF];
      stf_d   = stf_q & bus_wdata[B_STARTF];
      spf_d   = spf_q & bus_wdata[B_STOPF];
    end
    if (wr_start) begin
      run_d = bus_wdata[0];
      if (bus_wdata[0] && !run_q) stf_d = 1'b1;
      if (!bus_wdata[0] && run_q) spf_d = 1'b1;
    end
    if (wr_cmp)   cmp_d   = bus_wdata;
    if (match_ev) mflag_d = 1'b1;
    if (ovf_ev)   oflag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      run_q   <= 1'b0;
      cmp_q   <= '1;
      mflag_q <= 1'b0;
      oflag_q <= 1'b0;
      stf_q   <= 1'b0;
      spf_q   <= 1'b0;
    end else begin
      cfg_q   <= cfg_d;
      run_q   <= run_d;
      cmp_q   <= cmp_d;
      mflag_q <= mflag_d;
      oflag_q <= oflag_d;
      stf_q   <= stf_d;
      spf_q   <= spf_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_START: bus_rdata[0] = run_q;
      OFS_CTL: begin
        bus_rdata[B_MATCH]  = mflag_q;
        bus_rdata[B_OVF]    = oflag_q;
        bus_rdata[B_BUSY]   = pend;
        bus_rdata[B_STARTF] = stf_q;
        bus_rdata[B_STOPF]  = spf_q;
        bus_rdata[B_SSIE]   = cfg_q.ssie;
        bus_rdata[B_MODE9]  = cfg_q.mode9;
        bus_rdata[B_PERIOD] = cfg_q.periodic;
        bus_rdata[B_IE]     = cfg_q.ie;
        bus_rdata[5:4]      = cfg_q.route;
        bus_rdata[2:0]      = cfg_q.cks;
      end
      OFS_CNT: bus_rdata = cnt;
      OFS_CMP: bus_rdata = cmp_q;
      default: bus_rdata = '0;
    endcase
  end

  assign irq = ((cfg_q.route == ROUTE_IRQ) && cfg_q.ie && (mflag_q || oflag_q))
             || (cfg_q.ssie && (stf_q || spf_q));

  // R5
  match_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mflag_q) |-> $past(match_ev));
  // R7
  ovf_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oflag_q) |-> $past(ovf_ev));
  // R8
  match_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mflag_q) |-> $past(wr_ctl && !bus_wdata[B_MATCH]));
  // R9
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mflag_q || oflag_q || stf_q || spf_q));
  // R11
  stopped_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !pend) |=> $stable(cnt));
endmodule

// File: tb/cmt_channel_tb_top.sv
module cmt_channel_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_clk = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  localparam logic [7:0] A_START = 8'h00, A_CTL = 8'h10, A_CNT = 8'h14,
                         A_CMP = 8'h18, A_IRQ = 8'hFF;

  typedef struct {
    logic [7:0]  addr;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int    n_chk = 0;
  int    n_fail = 0;
  int    cycles = 0;
  bit    done = 0;

  always #10 clk = ~clk;

  cmt_channel dut_i (
    .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq));

  // monitor: pops one expected item per cycle and compares
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        act = (it.addr == A_IRQ) ? {31'b0, irq} : bus_rdata;
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.addr, act, it.exp);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic chk(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    bus_addr = (a == A_IRQ) ? A_START : a;
    it.addr = a; it.exp = e; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ref_clk = 1'b1;
      repeat (3) @(negedge clk);
      ref_clk = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic load_cnt(input logic [31:0] v);
    wr(A_CNT, v);
    pulses(2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(A_CTL, 32'h0, "R1");
    chk(A_CNT, 32'h0, "R1");
    chk(A_CMP, 32'hFFFF_FFFF, "R1");
    chk(A_START, 32'h0, "R1");
    chk(A_IRQ, 32'h0, "R1");

    // R2 undivided counting, R10 start/stop flags
    wr(A_CTL, 32'h7);
    wr(A_START, 32'h1);
    chk(A_CTL, 32'h1007, "R10");
    pulses(5);
    chk(A_CNT, 32'd5, "R2");
    wr(A_START, 32'h0);
    chk(A_CTL, 32'h1807, "R10");
    wr(A_CTL, 32'h7);
    chk(A_CTL, 32'h0007, "R10");

    // R11 stopped channel ignores edges
    pulses(3);
    chk(A_CNT, 32'd5, "R11");

    // R4 delayed load, busy bit, second write dropped
    wr(A_CNT, 32'd100);
    chk(A_CNT, 32'd5, "R4");
    chk(A_CTL, 32'h2007, "R4");
    wr(A_CNT, 32'd200);
    pulses(1);
    chk(A_CNT, 32'd5, "R4");
    pulses(1);
    chk(A_CNT, 32'd100, "R4");
    chk(A_CTL, 32'h0007, "R4");

    // R3 divide by 8
    load_cnt(32'd0);
    wr(A_CTL, 32'h4);
    wr(A_START, 32'h1);
    pulses(23);
    chk(A_CNT, 32'd2, "R3");
    pulses(1);
    chk(A_CNT, 32'd3, "R3");
    wr(A_START, 32'h0);
    // R3 divide by 32
    wr(A_CTL, 32'h5);
    load_cnt(32'd0);
    wr(A_START, 32'h1);
    pulses(31);
    chk(A_CNT, 32'd0, "R3");
    pulses(1);
    chk(A_CNT, 32'd1, "R3");
    wr(A_START, 32'h0);
    // R3 halting select
    wr(A_CTL, 32'h0);
    wr(A_START, 32'h1);
    pulses(4);
    chk(A_CNT, 32'd1, "R3");
    wr(A_START, 32'h0);

    // R5 free-running match keeps counting
    wr(A_CMP, 32'd3);
    load_cnt(32'd0);
    wr(A_CTL, 32'h7);
    wr(A_START, 32'h1);
    pulses(5);
    chk(A_CNT, 32'd5, "R5");
    chk(A_CTL, 32'h9007, "R5");
    wr(A_START, 32'h0);
    chk(A_IRQ, 32'h0, "R9");

    // R8 / R9 flag retention and interrupt gating
    wr(A_CTL, 32'h80A7);
    chk(A_CTL, 32'h80A7, "R8");
    chk(A_IRQ, 32'h1, "R9");
    wr(A_CTL, 32'h8097);
    chk(A_IRQ, 32'h0, "R9");
    wr(A_CTL, 32'h8027);
    chk(A_IRQ, 32'h0, "R9");
    wr(A_CTL, 32'h80A7);
    chk(A_IRQ, 32'h1, "R9");
    wr(A_CTL, 32'h00A7);
    chk(A_CTL, 32'h00A7, "R8");
    chk(A_IRQ, 32'h0, "R8");

    // R6 periodic clear on match
    wr(A_CTL, 32'h0107);
    load_cnt(32'd0);
    wr(A_START, 32'h1);
    pulses(4);
    chk(A_CNT, 32'd0, "R6");
    chk(A_CTL, 32'h9107, "R6");
    pulses(6);
    chk(A_CNT, 32'd2, "R6");
    wr(A_START, 32'h0);
    wr(A_CTL, 32'h0007);

    // R7 wrap and overflow flag
    load_cnt(32'hFFFF_FFFE);
    wr(A_START, 32'h1);
    pulses(1);
    chk(A_CNT, 32'hFFFF_FFFF, "R7");
    chk(A_CTL, 32'h1007, "R7");
    pulses(1);
    chk(A_CNT, 32'd0, "R7");
    chk(A_CTL, 32'h5007, "R7");
    wr(A_START, 32'h0);
    wr(A_CTL, 32'h40A7);
    chk(A_IRQ, 32'h1, "R9");
    wr(A_CTL, 32'h00A7);
    chk(A_CTL, 32'h00A7, "R8");
    chk(A_IRQ, 32'h0, "R9");

    // R10 start/stop interrupt enable
    wr(A_CTL, 32'h0407);
    chk(A_IRQ, 32'h0, "R10");
    wr(A_START, 32'h1);
    chk(A_IRQ, 32'h1, "R10");
    wr(A_CTL, 32'h0407);
    chk(A_IRQ, 32'h0, "R10");
    wr(A_START, 32'h0);
    chk(A_IRQ, 32'h1, "R10");

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule